// File: doc/BRIEF.md
# Single-Bit Serial Accumulator Core

This block is the execution core of a bit-serial processor. In every clock cycle it receives a 4-bit opcode and one data bit from the bus. It updates three architectural 1-bit registers: the accumulator, the carry and the write enable, here called the output gate. Wider arithmetic is built in software, one bit per instruction, with the carry register linking the steps. The program counter, address generation, memory and jump targets live outside the block. The core only reports a jump or a return through one-cycle strobes that external sequencing logic acts on.

Store results appear on a 1-bit bus output, together with a write strobe, in the same cycle as the store opcode. The strobe is raised only while the output gate is set. A hidden skip state machine lets a program discard the next instruction. It has two states. In `S_RUN`, opcodes execute. In `S_SKIP`, the current opcode is treated as a no-operation. The transition `S_RUN -> S_SKIP` is taken when a skip-on-zero instruction sees a zero accumulator, or when a return instruction executes. The transition `S_SKIP -> S_RUN` is always taken after one cycle. In every other case the machine stays in `S_RUN`. The architectural registers are also visible on output ports.

Top module: `bitcore`

## Requirements
- R1: After reset the accumulator is 0, the carry is 0, the output gate is 1 and the core is in `S_RUN`.
- R2: Opcode 1 loads the bus bit into the accumulator. Opcode 2 loads the inverted bus bit.
- R3: With the output gate set, opcode 3 drives the accumulator on `bus_o` and opcode 4 drives its inverse. In both cases `bus_we_o` is 1 in that same cycle.
- R4: Opcode 5 loads the output gate from the bus bit. While the output gate is 0, `bus_we_o` stays 0.
- R5: Opcode 6 is a full-adder step. The accumulator becomes acc^bus^carry. The carry becomes the majority of acc, bus and carry.
- R6: Opcodes 7, 8, 9 and A write acc XNOR bus, acc XOR bus, acc AND bus and acc OR bus into the accumulator.
- R7: Opcode B sets the accumulator to 1 and the carry to 0. Opcode C sets the accumulator to 0 and the carry to 1.
- R8: Opcode D raises `jump_o` for that cycle only and leaves all registers unchanged.
- R9: Opcode E moves the core to `S_SKIP` only when the accumulator is 0. With the accumulator at 1, the next opcode executes normally.
- R10: Opcode F raises `ret_o` for that cycle and always moves the core to `S_SKIP`.
- R11: In `S_SKIP` the opcode changes no register and raises no strobe. The core then returns to `S_RUN` for the following opcode.
- R12: Opcode 0 changes no register. Whenever `bus_we_o` is 0, `bus_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Opcode for this cycle |
| bus_i | input | 1 | Data bit read from the bus |
| bus_o | output | 1 | Data bit written to the bus |
| bus_we_o | output | 1 | Bus write strobe |
| jump_o | output | 1 | One-cycle jump request |
| ret_o | output | 1 | One-cycle return request |
| acc_o | output | 1 | Accumulator value |
| carry_o | output | 1 | Carry value |
| oen_o | output | 1 | Output gate value |

## Verification
Some properties hold on every cycle and are checked by assertions. A write strobe never appears while the output gate is clear. At most one of the write, jump and return strobes is active at a time. The bus stays low when nothing is written. A jump leaves all registers unchanged. A return suppresses every strobe and every register change in the cycle that follows it. The bench scenarios cover the arithmetic and logic values for all operand combinations. They also show that skip-on-zero depends on the accumulator, and that the skip lasts for exactly one opcode before normal execution resumes.

// File: rtl/bitcore_pkg.sv
package bitcore_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'h0,
        OP_LD   = 4'h1,
        OP_LDC  = 4'h2,
        OP_STO  = 4'h3,
        OP_STOC = 4'h4,
        OP_OEN  = 4'h5,
        OP_ADD  = 4'h6,
        OP_XNOR = 4'h7,
        OP_XOR  = 4'h8,
        OP_AND  = 4'h9,
        OP_OR   = 4'hA,
        OP_ONE  = 4'hB,
        OP_TWO  = 4'hC,
        OP_JMP  = 4'hD,
        OP_SKZ  = 4'hE,
        OP_RET  = 4'hF
    } op_e;

    typedef enum logic {
        S_RUN  = 1'b0,
        S_SKIP = 1'b1
    } skip_state_e;
endpackage

// File: rtl/bitcore_alu.sv
module bitcore_alu
    import bitcore_pkg::*;
(
    input  op_e  op,
    input  logic active,
    input  logic bus_in,
    input  logic acc,
    input  logic carry,
    input  logic oen,
    output logic acc_nx,
    output logic carry_nx,
    output logic oen_nx,
    output logic bus_out,
    output logic bus_we,
    output logic jump,
    output logic ret,
    output logic skip_set
);
    always_comb begin
        acc_nx   = acc;
        carry_nx = carry;
        oen_nx   = oen;
        bus_out  = 1'b0;
        bus_we   = 1'b0;
        jump     = 1'b0;
        ret      = 1'b0;
        skip_set = 1'b0;
        if (active) begin
            unique case (op)
                OP_NOP:  ;
                OP_LD:   acc_nx = bus_in;
                OP_LDC:  acc_nx = ~bus_in;
                OP_STO: begin
                    bus_we  = oen;
                    bus_out = oen & acc;
                end
                OP_STOC: begin
                    bus_we  = oen;
                    bus_out = oen & ~acc;
                end
                OP_OEN:  oen_nx = bus_in;
                OP_ADD: begin
                    acc_nx   = acc ^ bus_in ^ carry;
                    carry_nx = (acc & bus_in) | (acc & carry) | (bus_in & carry);
                end
                OP_XNOR: acc_nx = ~(acc ^ bus_in);
                OP_XOR:  acc_nx = acc ^ bus_in;
                OP_AND:  acc_nx = acc & bus_in;
                OP_OR:   acc_nx = acc | bus_in;
                OP_ONE: begin
                    acc_nx   = 1'b1;
                    carry_nx = 1'b0;
                end
                OP_TWO: begin
                    acc_nx   = 1'b0;
                    carry_nx = 1'b1;
                end
                OP_JMP:  jump = 1'b1;
                OP_SKZ:  skip_set = ~acc;
                OP_RET: begin
                    ret      = 1'b1;
                    skip_set = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/bitcore_seq.sv
module bitcore_seq
    import bitcore_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic skip_set,
    input  logic acc_nx,
    input  logic carry_nx,
    input  logic oen_nx,
    output logic active,
    output logic acc,
    output logic carry,
    output logic oen
);
    skip_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RUN;
            acc     <= 1'b0;
            carry   <= 1'b0;
            oen     <= 1'b1;
        end else begin
            state_q <= state_d;
            acc     <= acc_nx;
            carry   <= carry_nx;
            oen     <= oen_nx;
        end
    end

    always_comb begin
        state_d = state_q;
        active  = 1'b0;
        unique case (state_q)
            S_RUN: begin
                active  = 1'b1;
                state_d = skip_set ? S_SKIP : S_RUN;
            end
            S_SKIP: begin
                active  = 1'b0;
                state_d = S_RUN;
            end
        endcase
    end
endmodule

// File: rtl/bitcore.sv
module bitcore
    import bitcore_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op_i,
    input  logic            bus_i,
    output logic            bus_o,
    output logic            bus_we_o,
    output logic            jump_o,
    output logic            ret_o,
    output logic            acc_o,
    output logic            carry_o,
    output logic            oen_o
);
    logic active, skip_set;
    logic acc_nx, carry_nx, oen_nx;

    bitcore_alu u_alu (
        .op       (op_e'(op_i)),
        .active   (active),
        .bus_in   (bus_i),
        .acc      (acc_o),
        .carry    (carry_o),
        .oen      (oen_o),
        .acc_nx   (acc_nx),
        .carry_nx (carry_nx),
        .oen_nx   (oen_nx),
        .bus_out  (bus_o),
        .bus_we   (bus_we_o),
        .jump     (jump_o),
        .ret      (ret_o),
        .skip_set (skip_set)
    );

    bitcore_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .skip_set (skip_set),
        .acc_nx   (acc_nx),
        .carry_nx (carry_nx),
        .oen_nx   (oen_nx),
        .active   (active),
        .acc      (acc_o),
        .carry    (carry_o),
        .oen      (oen_o)
    );
endmodule

// File: rtl/bitcore_chk.sv
module bitcore_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_o,
    input logic bus_we_o,
    input logic jump_o,
    input logic ret_o,
    input logic acc_o,
    input logic carry_o,
    input logic oen_o
);
    p_we_needs_oen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we_o |-> oen_o);

    p_strobes_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_we_o, jump_o, ret_o}));

    p_jump_keeps_regs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        jump_o |=> ($stable(acc_o) && $stable(carry_o) && $stable(oen_o)));

    p_ret_mutes_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ret_o |=> (!ret_o && !jump_o && !bus_we_o));

    p_skipped_no_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ret_o) && $past(rst_n)) |=>
            ($stable(acc_o) && $stable(carry_o) && $stable(oen_o)));

    p_bus_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_o |-> !bus_o);
endmodule

bind bitcore bitcore_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_o    (bus_o),
    .bus_we_o (bus_we_o),
    .jump_o   (jump_o),
    .ret_o    (ret_o),
    .acc_o    (acc_o),
    .carry_o  (carry_o),
    .oen_o    (oen_o)
);

// File: tb/test_bitcore.sv
module test_bitcore;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = 4'h0;
    logic       bus_i = 1'b0;
    logic       bus_o, bus_we_o, jump_o, ret_o, acc_o, carry_o, oen_o;

    logic s_bus, s_we, s_jmp, s_ret;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitcore i_bitcore (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .bus_i(bus_i),
        .bus_o(bus_o), .bus_we_o(bus_we_o), .jump_o(jump_o), .ret_o(ret_o),
        .acc_o(acc_o), .carry_o(carry_o), .oen_o(oen_o)
    );

    task automatic check(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // One instruction per cycle: drive at negedge, sample strobes, then let the edge update registers.
    task automatic apply(logic [3:0] op, logic b);
        @(negedge clk);
        op_i  = op;
        bus_i = b;
        #1;
        s_bus = bus_o;
        s_we  = bus_we_o;
        s_jmp = jump_o;
        s_ret = ret_o;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        check("R1 acc after reset", acc_o, 1'b0);
        check("R1 carry after reset", carry_o, 1'b0);
        check("R1 oen after reset", oen_o, 1'b1);
        apply(4'h1, 1'b1);
        check("R1 not skipping after reset", acc_o, 1'b1);
    endtask

    task automatic t_load;
        apply(4'h1, 1'b0); check("R2 LD 0", acc_o, 1'b0);
        apply(4'h1, 1'b1); check("R2 LD 1", acc_o, 1'b1);
        apply(4'h2, 1'b1); check("R2 LDC 1", acc_o, 1'b0);
        apply(4'h2, 1'b0); check("R2 LDC 0", acc_o, 1'b1);
    endtask

    task automatic t_store;
        apply(4'hB, 1'b0);
        apply(4'h3, 1'b0);
        check("R3 STO we", s_we, 1'b1); check("R3 STO data", s_bus, 1'b1);
        apply(4'h4, 1'b0);
        check("R3 STOC we", s_we, 1'b1); check("R3 STOC data", s_bus, 1'b0);
        apply(4'h0, 1'b1);
        check("R12 NOP we", s_we, 1'b0); check("R12 NOP bus low", s_bus, 1'b0);
        check("R12 NOP acc", acc_o, 1'b1); check("R12 NOP carry", carry_o, 1'b0);
        check("R12 NOP oen", oen_o, 1'b1);
    endtask

    task automatic t_gate;
        apply(4'h5, 1'b0); check("R4 OEN 0", oen_o, 1'b0);
        apply(4'h3, 1'b0);
        check("R4 STO gated we", s_we, 1'b0); check("R4 STO gated bus", s_bus, 1'b0);
        apply(4'h4, 1'b0); check("R4 STOC gated we", s_we, 1'b0);
        apply(4'h5, 1'b1); check("R4 OEN 1", oen_o, 1'b1);
        apply(4'h3, 1'b0); check("R4 STO after reenable", s_we, 1'b1);
    endtask

    task automatic t_add;
        for (int v = 0; v < 8; v++) begin
            logic a, b, c;
            a = v[2]; b = v[1]; c = v[0];
            apply(c ? 4'hC : 4'hB, 1'b0);
            apply(4'h1, a);
            apply(4'h6, b);
            check("R5 ADD sum", acc_o, a ^ b ^ c);
            check("R5 ADD carry", carry_o, (a & b) | (a & c) | (b & c));
        end
    endtask

    task automatic t_logic;
        for (int o = 7; o <= 10; o++) begin
            for (int v = 0; v < 4; v++) begin
                logic a, b, e;
                a = v[1]; b = v[0];
                case (o)
                    7: e = ~(a ^ b);
                    8: e = a ^ b;
                    9: e = a & b;
                    default: e = a | b;
                endcase
                apply(4'h1, a);
                apply(4'(o), b);
                check("R6 logic op", acc_o, e);
            end
        end
    endtask

    task automatic t_onetwo;
        apply(4'hC, 1'b1);
        check("R7 TWO acc", acc_o, 1'b0); check("R7 TWO carry", carry_o, 1'b1);
        apply(4'hB, 1'b0);
        check("R7 ONE acc", acc_o, 1'b1); check("R7 ONE carry", carry_o, 1'b0);
    endtask

    task automatic t_jump;
        apply(4'hB, 1'b0);
        apply(4'hD, 1'b1);
        check("R8 jump strobe", s_jmp, 1'b1); check("R8 no write", s_we, 1'b0);
        check("R8 acc kept", acc_o, 1'b1); check("R8 carry kept", carry_o, 1'b0);
        check("R8 oen kept", oen_o, 1'b1);
        apply(4'h0, 1'b0);
        check("R8 strobe one cycle", s_jmp, 1'b0);
    endtask

    task automatic t_skz;
        apply(4'h1, 1'b0);
        apply(4'hE, 1'b0);
        apply(4'h1, 1'b1);
        check("R9 SKZ zero skips LD", acc_o, 1'b0);
        apply(4'h1, 1'b1);
        check("R11 skip lasts one opcode", acc_o, 1'b1);
        apply(4'hE, 1'b0);
        apply(4'h1, 1'b0);
        check("R9 SKZ one no skip", acc_o, 1'b0);
    endtask

    task automatic t_ret;
        apply(4'hB, 1'b0);
        apply(4'hF, 1'b0);
        check("R10 ret strobe", s_ret, 1'b1);
        apply(4'hD, 1'b0);
        check("R11 skipped JMP", s_jmp, 1'b0);
        apply(4'h3, 1'b0);
        check("R10 run after skip", s_we, 1'b1);
        apply(4'hF, 1'b0);
        apply(4'hC, 1'b0);
        check("R11 skipped TWO acc", acc_o, 1'b1);
        check("R11 skipped TWO carry", carry_o, 1'b0);
        apply(4'hF, 1'b0);
        apply(4'h3, 1'b0);
        check("R11 skipped STO no write", s_we, 1'b0);
        apply(4'hF, 1'b0);
        apply(4'hF, 1'b0);
        check("R11 skipped RET no strobe", s_ret, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset_pre();
    end

    task automatic t_reset_pre;
        check("R1 acc in reset", acc_o, 1'b0);
        check("R1 oen in reset", oen_o, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_load();
        t_store();
        t_gate();
        t_add();
        t_logic();
        t_onetwo();
        t_jump();
        t_skz();
        t_ret();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule